// File: doc/BRIEF.md
# Power-Up Recall and Brownout Supervisor

This block watches the supply of a nonvolatile static memory through three digital comparator flags and decides when the memory may be used. At power-on, and again whenever the supply sinks below the deep reset threshold, it arms a pending-recall latch. Once the supply climbs back above the higher switch threshold, it launches an automatic recall. The recall copies the nonvolatile image back into the array and is timed by a cycle counter. Until the recall has finished, normal access is held off.

A shallow brownout is one that falls below the switch threshold but never reaches the reset threshold. It leaves the latch untouched, so no recall follows when the supply recovers. The block also tells the memory controller when store cycles must be suppressed. It reports standby only once every nonvolatile cycle in progress has ended. The comparator flags come from analog circuits, so each passes through a synchronizer. The controller-side inputs are already synchronous to the clock. There is no data stream through this block: all pins are plain control and status levels.

Top module: `pwr_recall_sup`

## Requirements
- R1: While reset is asserted and right after it, the pending-recall latch is armed, `mem_ready` is 0, `store_inhibit` is 1 and `recall_active` is 0.
- R2: Any cycle in which the synchronized below-reset flag is 1 arms the pending-recall latch.
- R3: A recall starts only when the latch is armed, the synchronized above-switch flag is 1, the below-reset flag is 0 and no recall is running. Starting a recall clears the latch.
- R4: `recall_active` stays high for exactly `RESTORE_CYC` consecutive clock cycles per recall.
- R5: A dip that drops the above-switch flag while the below-reset flag stays 0 produces no recall when the supply returns.
- R6: `mem_ready` is 1 exactly when the synchronized above-switch flag is 1, the latch is clear and no recall is running.
- R7: `store_inhibit` is 1 whenever the synchronized above-inhibit flag is 0, the latch is armed, or a recall is running.
- R8: `standby_ok` is 1 only when `host_deselect` is 1, `store_busy` is 0 and no recall is running.
- R9: A below-reset dip during a running recall does not cut that recall short. It re-arms the latch, and a second recall follows once the first has ended and the supply is back above the switch level.
- R10: Each supply flag passes through `SYNC_STAGES` flip-flops. After reset these flops read as "below reset, not above switch, not above inhibit". A flag change therefore reaches the outputs `SYNC_STAGES` cycles later, or `SYNC_STAGES`+1 cycles later when it starts a recall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_below_reset | input | 1 | Comparator flag: supply below the reset level (asynchronous) |
| supply_above_switch | input | 1 | Comparator flag: supply above the switch level (asynchronous) |
| supply_above_inhibit | input | 1 | Comparator flag: supply above the store-inhibit level (asynchronous) |
| host_deselect | input | 1 | Controller has the memory deselected |
| store_busy | input | 1 | Controller's nonvolatile store cycle is in progress |
| recall_active | output | 1 | Automatic recall running; drives the array controller |
| mem_ready | output | 1 | Normal SRAM access allowed |
| store_inhibit | output | 1 | Store cycles must not start |
| standby_ok | output | 1 | Standby may be reported |

## Verification
A latch that wrongly stays clear shows at the ports as a missing recall: `mem_ready` rises `SYNC_STAGES` cycles after the supply returns, when it should stay low for `RESTORE_CYC` more cycles. A latch that wrongly stays set shows as an extra recall, or as `store_inhibit` stuck high. A counter that is off by one changes the length of the `recall_active` pulse by one cycle, which appears at the end of each recall. The bench runs a cycle-level model beside the design and compares all four outputs on every cycle, so any of these faults is caught in the first cycle where it shows.

// File: rtl/pwr_recall_pkg.sv
package pwr_recall_pkg;
  // Supply comparator flags, ordered MSB first.
  typedef struct packed {
    logic below_rst;
    logic above_sw;
    logic above_inh;
  } supply_flags_t;

  localparam int unsigned FLAG_W = $bits(supply_flags_t);
  // Safe state assumed until the synchronizer has real samples.
  localparam supply_flags_t FLAGS_SAFE = '{below_rst: 1'b1, above_sw: 1'b0, above_inh: 1'b0};
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_async;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/recall_arm.sv
module recall_arm
  import pwr_recall_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  supply_flags_t flags_s,
  input  logic          busy,
  output logic          start,
  output logic          pending
);
  assign start = pending && flags_s.above_sw && !flags_s.below_rst && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pending <= 1'b1;
    else if (flags_s.below_rst) pending <= 1'b1;
    else if (start)             pending <= 1'b0;
  end

  // R2: a deep dip always leaves the latch armed
  a_r2_deep_dip_arms: assert property (@(posedge clk) disable iff (!rst_n)
    flags_s.below_rst |=> pending);

  // R9: a deep dip during a running recall re-arms the latch
  a_r9_rearm_in_recall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && flags_s.below_rst) |=> (pending && busy || pending));
endmodule

// File: rtl/restore_timer.sv
module restore_timer #(
  parameter int unsigned CYCLES = 27500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LAST;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // R4: the recall cannot end while cycles remain
  a_r4_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);

  // R4: the count never exceeds its load value
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= LAST);
endmodule

// File: rtl/pwr_recall_sup.sv
module pwr_recall_sup
  import pwr_recall_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RESTORE_CYC = 27500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_below_reset,
  input  logic supply_above_switch,
  input  logic supply_above_inhibit,
  input  logic host_deselect,
  input  logic store_busy,
  output logic recall_active,
  output logic mem_ready,
  output logic store_inhibit,
  output logic standby_ok
);
  supply_flags_t flags_raw, flags_s;
  logic [FLAG_W-1:0] flags_q;
  logic start, pending;

  assign flags_raw = '{below_rst: supply_below_reset,
                       above_sw:  supply_above_switch,
                       above_inh: supply_above_inhibit};

  flag_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES), .RST_VAL(FLAGS_SAFE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(flags_raw), .q_sync(flags_q));

  assign flags_s = supply_flags_t'(flags_q);

  recall_arm u_arm (
    .clk(clk), .rst_n(rst_n), .flags_s(flags_s), .busy(recall_active),
    .start(start), .pending(pending));

  restore_timer #(.CYCLES(RESTORE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(recall_active));

  assign mem_ready     = flags_s.above_sw && !pending && !recall_active;
  assign store_inhibit = !flags_s.above_inh || pending || recall_active;
  assign standby_ok    = host_deselect && !store_busy && !recall_active;

  // R3: a recall begins only from an armed latch with supply above switch
  a_r3_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recall_active) |-> ($past(pending) && $past(flags_s.above_sw)));

  // R6: access is never granted while a recall runs
  a_r6_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |-> !recall_active);
endmodule

// File: tb/tb_pwr_recall_sup.sv
module tb_pwr_recall_sup;
  localparam int unsigned SYNC = 2;
  localparam int unsigned REST = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic b_rst = 1'b1, a_sw = 1'b0, a_inh = 1'b0, desel = 1'b0, sbusy = 1'b0;
  logic recall_active, mem_ready, store_inhibit, standby_ok;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pwr_recall_sup #(.SYNC_STAGES(SYNC), .RESTORE_CYC(REST)) dut (
    .clk(clk), .rst_n(rst_n), .supply_below_reset(b_rst), .supply_above_switch(a_sw),
    .supply_above_inhibit(a_inh), .host_deselect(desel), .store_busy(sbusy),
    .recall_active(recall_active), .mem_ready(mem_ready),
    .store_inhibit(store_inhibit), .standby_ok(standby_ok));

  // Reference model built from the requirements (R1, R2, R3, R4, R10)
  logic [2:0] m_sync [SYNC];
  logic m_pend, m_act;
  int   m_left;
  always @(posedge clk or negedge rst_n) begin
    logic st;
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) m_sync[i] = 3'b100;
      m_pend = 1'b1; m_act = 1'b0; m_left = 0;
    end else begin
      st = m_pend && m_sync[SYNC-1][1] && !m_sync[SYNC-1][2] && !m_act;
      if (m_sync[SYNC-1][2]) m_pend = 1'b1;
      else if (st)           m_pend = 1'b0;
      if (st) begin m_act = 1'b1; m_left = REST - 1; end
      else if (m_act) begin
        if (m_left == 0) m_act = 1'b0; else m_left--;
      end
      for (int i = SYNC-1; i > 0; i--) m_sync[i] = m_sync[i-1];
      m_sync[0] = {b_rst, a_sw, a_inh};
    end
  end

  function automatic logic exp_ready();
    return m_sync[SYNC-1][1] && !m_pend && !m_act;
  endfunction
  function automatic logic exp_inhibit();
    return !m_sync[SYNC-1][0] || m_pend || m_act;
  endfunction
  function automatic logic exp_standby();
    return desel && !sbusy && !m_act;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison of all outputs against the model
  task automatic cmp_all();
    chk("R4/R9 recall_active", recall_active, m_act);
    chk("R6 mem_ready", mem_ready, exp_ready());
    chk("R7 store_inhibit", store_inhibit, exp_inhibit());
    chk("R8 standby_ok", standby_ok, exp_standby());
  endtask

  // Supply level: 0 below reset, 1 reset..inhibit, 2 inhibit..switch, 3 above switch
  task automatic set_level(int lv);
    b_rst = (lv == 0);
    a_sw  = (lv == 3);
    a_inh = (lv >= 2);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_all();
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int lv, hold, cnt;
    void'($urandom(32'd1234));
    set_level(0);
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 ready in reset", mem_ready, 1'b0);
    chk("R1 inhibit in reset", store_inhibit, 1'b1);
    chk("R1 recall in reset", recall_active, 1'b0);
    rst_n = 1'b1;
    step(4);

    // R3/R10: power up; recall rises SYNC+1 edges after the change
    set_level(3);
    step(SYNC);
    chk("R10 no recall before sync", recall_active, 1'b0);
    chk("R3 not ready before recall", mem_ready, 1'b0);
    step(1);
    chk("R3 recall started", recall_active, 1'b1);
    // R4: measure the pulse length
    cnt = 1;
    while (recall_active && cnt < 1000) begin step(1); if (recall_active) cnt++; end
    checks++;
    if (cnt != REST) begin errors++; $display("FAIL R4 length actual=%0d expected=%0d", cnt, REST); end
    chk("R6 ready after recall", mem_ready, 1'b1);

    // R5: shallow brownout, no recall
    set_level(2); step(6);
    chk("R5 not ready during brownout", mem_ready, 1'b0);
    set_level(3); step(SYNC + 3);
    chk("R5 no recall after shallow dip", recall_active, 1'b0);
    chk("R5 ready after shallow dip", mem_ready, 1'b1);

    // R2: deep dip then return gives a recall
    set_level(0); step(5);
    chk("R2 inhibit after deep dip", store_inhibit, 1'b1);
    set_level(3); step(SYNC + 1);
    chk("R2 recall after deep dip", recall_active, 1'b1);

    // R9: deep dip in the middle of the recall
    step(4);
    set_level(0); step(3);
    set_level(3); step(2);
    chk("R9 recall not cut short", recall_active, 1'b1);
    cnt = 0;
    while (recall_active && cnt < 1000) begin step(1); cnt++; end
    step(1);
    chk("R9 second recall follows", recall_active, 1'b1);
    step(REST + 2);
    chk("R9 ready after second recall", mem_ready, 1'b1);

    // R8: standby held off by a store in progress
    desel = 1'b1; sbusy = 1'b1; step(1);
    chk("R8 standby blocked by store", standby_ok, 1'b0);
    sbusy = 1'b0; step(1);
    chk("R8 standby when idle", standby_ok, 1'b1);

    // Constrained random walk over supply levels and controller inputs
    lv = 3;
    for (int k = 0; k < 150; k++) begin
      lv = (lv + int'($urandom_range(2, 0)) - 1);
      if (lv < 0) lv = 0;
      if (lv > 3) lv = 3;
      set_level(lv);
      hold = int'($urandom_range(REST + 8, 1));
      for (int j = 0; j < hold; j++) begin
        desel = 1'($urandom_range(1, 0));
        sbusy = 1'($urandom_range(1, 0));
        step(1);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule